// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Unit

This block is the retire stage of an out-of-order core that runs several hardware threads. Each cycle it looks at the oldest entries of every thread's reorder buffer, as a small per-thread window supplied by the buffer. It walks a chain of examination slots in program order. Each slot asks a round-robin thread selector for a thread and then decides what to do with that thread's current head. The head can be retired, dropped because it was squashed, held back, turned into a request to execute it non-speculatively, or turned into the start of a trap.

The outputs are the number of entries to pop from each thread's buffer, a clear strobe for the head's can-commit flag, a single non-speculative execute request (optionally marked uncached), a trap start, and registered per-thread state. That state is the youngest retired sequence number, the committed PC pair, a trap-pending flag, a free-entry broadcast and three simple counters. Serialising instructions and faults act only when nothing has been committed earlier in the cycle and no stores are waiting for writeback. Squashed heads leave the buffer without using any of the commit bandwidth.

Top module: `retire_unit`

## Requirements
- R1: Per cycle at most WIDTH non-squashed heads retire, each thread's entries in window order from index 0. The walk stops at the first selected head whose ready bit is 0, when no thread has a valid head, when WIDTH retires are reached, or after LOOK examinations. `pop_cnt[t]` gives the combinational number of entries removed from thread t.
- R2: A ready head with the squashed bit set is popped and adds one to `sq_cnt`, but does not count toward WIDTH. A cycle may therefore pop up to LOOK entries.
- R3: A ready, unexecuted head with the serial bit set raises `ns_vld` with `ns_uncached`=0, `ns_seq`=its sequence number, `ns_tid` and the matching `clr_ready` bit, and it is not popped. This happens only if no head has retired earlier in the same cycle and `store_wb_pend` is 0. Otherwise it stalls with no request. Either way the walk stops.
- R4: A ready, unexecuted, non-serial head with the load bit set raises `ns_vld` with `ns_uncached`=1 and its `clr_ready` bit, is not popped, and stops the walk. This does not depend on earlier retires or on `store_wb_pend`.
- R5: A ready, executed head with the fault bit set pulses `trap_vld`/`trap_tid`, is not popped, and sets `trap_pend[t]` from the next cycle. This happens only if no head has retired earlier in the cycle and `store_wb_pend` is 0; otherwise it stalls. A thread whose `trap_pend` bit is 1 is never selected. `trap_clr[t]` clears that bit at the next edge.
- R6: When a thread retires heads, the next cycle shows `done_seq[t]` equal to the youngest retired sequence number and `cmt_pc[t]` equal to its next-PC field. It also shows `cmt_npc[t]` equal to that value plus INSN_BYTES.
- R7: `idone_cnt[t]` adds one for each retired head of thread t whose no-count bit (nop or instruction prefetch) is 0.
- R8: `full_cnt` adds one for each cycle in which exactly WIDTH heads retire.
- R9: In the cycle after thread t pops any entry, `free_upd[t]` is 1 and `free_cnt[t]` carries `rob_free[t]`. Otherwise they are 0.
- R10: Each slot picks the first thread, searching upward (with wrap) from a rotating pointer, that has a valid head at its current window position and is not trap-pending. The pointer is 0 after reset and advances by one every cycle.
- R11: After reset all registered outputs and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_valid | input | THREADS*LOOK | Window entry holds an instruction |
| hd_ready | input | THREADS*LOOK | Entry's can-commit flag |
| hd_squashed | input | THREADS*LOOK | Entry was squashed |
| hd_exec | input | THREADS*LOOK | Entry has executed |
| hd_serial | input | THREADS*LOOK | Non-speculative, store-conditional or barrier |
| hd_load | input | THREADS*LOOK | Entry is a load |
| hd_fault | input | THREADS*LOOK | Entry carries a fault |
| hd_nocount | input | THREADS*LOOK | Nop or instruction prefetch |
| hd_seq | input | THREADS*LOOK*SEQ_W | Sequence numbers |
| hd_npc | input | THREADS*LOOK*PC_W | Next-PC of each entry |
| store_wb_pend | input | 1 | Stores are waiting for writeback |
| trap_clr | input | THREADS | Trap handling finished per thread |
| rob_free | input | THREADS*FREE_W | Free entries per thread buffer |
| pop_cnt | output | THREADS*OFF_W | Entries removed per thread this cycle |
| clr_ready | output | THREADS | Clear can-commit of current head |
| ns_vld | output | 1 | Non-speculative execute request |
| ns_tid | output | TID_W | Thread of the request |
| ns_seq | output | SEQ_W | Sequence number of the request |
| ns_uncached | output | 1 | Request is an uncached load |
| trap_vld | output | 1 | Trap start pulse |
| trap_tid | output | TID_W | Thread taking the trap |
| trap_pend | output | THREADS | Trap pending per thread |
| done_seq | output | THREADS*SEQ_W | Youngest retired sequence number |
| cmt_pc | output | THREADS*PC_W | Committed PC |
| cmt_npc | output | THREADS*PC_W | Committed next PC |
| free_upd | output | THREADS | Free-count broadcast valid |
| free_cnt | output | THREADS*FREE_W | Broadcast free count |
| idone_cnt | output | THREADS*CNT_W | Counted retired instructions |
| sq_cnt | output | CNT_W | Squashed entries popped |
| full_cnt | output | CNT_W | Cycles at full commit width |

## Verification
Squashed-head retirement and a serialising request can fall in the same cycle. So can an ordinary retire and a serialising or faulting head behind it. The bench provokes both by loading the window with squashed entries ahead of a serial head, which must then still issue its request. It also places an executed head ahead of a serial or faulting head, which must then stall. The pop count, the request and trap strobes, and the squashed counter are all compared in that one cycle, and the same window is repeated with stores pending to confirm the store gate.

// File: rtl/retire_pkg.sv
package retire_pkg;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RETIRE,
        ACT_SQUASH,
        ACT_NONSPEC,
        ACT_UNCACHED,
        ACT_TRAP
    } act_e;

endpackage

// File: rtl/retire_pick.sv
module retire_pick #(
    parameter int THREADS = 2,
    parameter int TID_W   = 1
) (
    input  logic [TID_W-1:0]   start,
    input  logic [THREADS-1:0] elig,
    output logic               found,
    output logic [TID_W-1:0]   tid
);

    always_comb begin
        found = 1'b0;
        tid   = '0;
        for (int k = 0; k < THREADS; k++) begin
            int t;
            t = (int'(start) + k) % THREADS;
            if (!found && elig[t]) begin
                found = 1'b1;
                tid   = TID_W'(t);
            end
        end
    end

endmodule

// File: rtl/retire_slot.sv
module retire_slot
    import retire_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int LOOK    = 4,
    parameter int WIDTH   = 2,
    parameter int SEQ_W   = 16,
    parameter int PC_W    = 32,
    parameter int TID_W   = 1,
    parameter int OFF_W   = 3,
    parameter int CMT_W   = 2
) (
    input  logic [TID_W-1:0]                          rr,
    input  logic [THREADS-1:0]                        trap_pend,
    input  logic                                      store_wb_pend,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_valid,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_ready,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_squashed,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_exec,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_serial,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_load,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_fault,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_nocount,
    input  logic [THREADS-1:0][LOOK-1:0][SEQ_W-1:0]   hd_seq,
    input  logic [THREADS-1:0][LOOK-1:0][PC_W-1:0]    hd_npc,
    input  logic [THREADS-1:0][OFF_W-1:0]             off_in,
    input  logic [CMT_W-1:0]                          cmt_in,
    input  logic                                      run_in,
    output logic [THREADS-1:0][OFF_W-1:0]             off_out,
    output logic [CMT_W-1:0]                          cmt_out,
    output logic                                      run_out,
    output act_e                                      act,
    output logic [TID_W-1:0]                          act_tid,
    output logic [SEQ_W-1:0]                          act_seq,
    output logic [PC_W-1:0]                           act_npc,
    output logic                                      act_cnt
);

    localparam int IDX_W = (LOOK > 1) ? $clog2(LOOK) : 1;

    logic [THREADS-1:0] elig;
    logic               sel_vld;
    logic [TID_W-1:0]   sel_tid;
    logic [IDX_W-1:0]   idx;
    logic               lead_ok;

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            elig[t] = run_in
                   && (cmt_in < CMT_W'(WIDTH))
                   && (off_in[t] < OFF_W'(LOOK))
                   && hd_valid[t][off_in[t][IDX_W-1:0]]
                   && !trap_pend[t];
        end
    end

    retire_pick #(
        .THREADS (THREADS),
        .TID_W   (TID_W)
    ) u_pick (
        .start (rr),
        .elig  (elig),
        .found (sel_vld),
        .tid   (sel_tid)
    );

    always_comb begin
        off_out = off_in;
        cmt_out = cmt_in;
        run_out = run_in;
        act     = ACT_NONE;
        act_tid = sel_tid;
        idx     = off_in[sel_tid][IDX_W-1:0];
        act_seq = hd_seq[sel_tid][idx];
        act_npc = hd_npc[sel_tid][idx];
        act_cnt = !hd_nocount[sel_tid][idx];
        lead_ok = (cmt_in == '0) && !store_wb_pend;

        if (!sel_vld || !hd_ready[sel_tid][idx]) begin
            run_out = 1'b0;
        end else if (hd_squashed[sel_tid][idx]) begin
            act              = ACT_SQUASH;
            off_out[sel_tid] = off_in[sel_tid] + 1'b1;
        end else if (!hd_exec[sel_tid][idx]) begin
            run_out = 1'b0;
            if (hd_serial[sel_tid][idx]) begin
                if (lead_ok) act = ACT_NONSPEC;
            end else if (hd_load[sel_tid][idx]) begin
                act = ACT_UNCACHED;
            end
        end else if (hd_fault[sel_tid][idx]) begin
            run_out = 1'b0;
            if (lead_ok) act = ACT_TRAP;
        end else begin
            act              = ACT_RETIRE;
            off_out[sel_tid] = off_in[sel_tid] + 1'b1;
            cmt_out          = cmt_in + 1'b1;
        end
    end

endmodule

// File: rtl/retire_unit.sv
module retire_unit
    import retire_pkg::*;
#(
    parameter int THREADS    = 2,
    parameter int LOOK       = 4,
    parameter int WIDTH      = 2,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4,
    parameter int FREE_W     = 8,
    parameter int CNT_W      = 16,
    localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int OFF_W     = $clog2(LOOK + 1),
    localparam int CMT_W     = $clog2(WIDTH + 1)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_valid,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_ready,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_squashed,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_exec,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_serial,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_load,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_fault,
    input  logic [THREADS-1:0][LOOK-1:0]              hd_nocount,
    input  logic [THREADS-1:0][LOOK-1:0][SEQ_W-1:0]   hd_seq,
    input  logic [THREADS-1:0][LOOK-1:0][PC_W-1:0]    hd_npc,
    input  logic                                      store_wb_pend,
    input  logic [THREADS-1:0]                        trap_clr,
    input  logic [THREADS-1:0][FREE_W-1:0]            rob_free,
    output logic [THREADS-1:0][OFF_W-1:0]             pop_cnt,
    output logic [THREADS-1:0]                        clr_ready,
    output logic                                      ns_vld,
    output logic [TID_W-1:0]                          ns_tid,
    output logic [SEQ_W-1:0]                          ns_seq,
    output logic                                      ns_uncached,
    output logic                                      trap_vld,
    output logic [TID_W-1:0]                          trap_tid,
    output logic [THREADS-1:0]                        trap_pend,
    output logic [THREADS-1:0][SEQ_W-1:0]             done_seq,
    output logic [THREADS-1:0][PC_W-1:0]              cmt_pc,
    output logic [THREADS-1:0][PC_W-1:0]              cmt_npc,
    output logic [THREADS-1:0]                        free_upd,
    output logic [THREADS-1:0][FREE_W-1:0]            free_cnt,
    output logic [THREADS-1:0][CNT_W-1:0]             idone_cnt,
    output logic [CNT_W-1:0]                          sq_cnt,
    output logic [CNT_W-1:0]                          full_cnt
);

    typedef struct packed {
        logic [THREADS-1:0][PC_W-1:0]  pc;
        logic [THREADS-1:0][PC_W-1:0]  npc;
        logic [THREADS-1:0][SEQ_W-1:0] done;
        logic [THREADS-1:0]            trap;
        logic [THREADS-1:0]            chg;
        logic [TID_W-1:0]              rr;
        logic [THREADS-1:0][CNT_W-1:0] idone;
        logic [CNT_W-1:0]              sq;
        logic [CNT_W-1:0]              full;
    } state_t;

    state_t st_d, st_q;

    // Slot chain carries
    logic [THREADS-1:0][OFF_W-1:0] off_c [LOOK+1];
    logic [CMT_W-1:0]              cmt_c [LOOK+1];
    logic                          run_c [LOOK+1];
    act_e                          act_c [LOOK];
    logic [TID_W-1:0]              tid_c [LOOK];
    logic [SEQ_W-1:0]              seq_c [LOOK];
    logic [PC_W-1:0]               npc_c [LOOK];
    logic                          cnt_c [LOOK];

    assign off_c[0] = '0;
    assign cmt_c[0] = '0;
    assign run_c[0] = 1'b1;

    for (genvar s = 0; s < LOOK; s++) begin : g_slot
        retire_slot #(
            .THREADS (THREADS),
            .LOOK    (LOOK),
            .WIDTH   (WIDTH),
            .SEQ_W   (SEQ_W),
            .PC_W    (PC_W),
            .TID_W   (TID_W),
            .OFF_W   (OFF_W),
            .CMT_W   (CMT_W)
        ) u_slot (
            .rr            (st_q.rr),
            .trap_pend     (st_q.trap),
            .store_wb_pend (store_wb_pend),
            .hd_valid      (hd_valid),
            .hd_ready      (hd_ready),
            .hd_squashed   (hd_squashed),
            .hd_exec       (hd_exec),
            .hd_serial     (hd_serial),
            .hd_load       (hd_load),
            .hd_fault      (hd_fault),
            .hd_nocount    (hd_nocount),
            .hd_seq        (hd_seq),
            .hd_npc        (hd_npc),
            .off_in        (off_c[s]),
            .cmt_in        (cmt_c[s]),
            .run_in        (run_c[s]),
            .off_out       (off_c[s+1]),
            .cmt_out       (cmt_c[s+1]),
            .run_out       (run_c[s+1]),
            .act           (act_c[s]),
            .act_tid       (tid_c[s]),
            .act_seq       (seq_c[s]),
            .act_npc       (npc_c[s]),
            .act_cnt       (cnt_c[s])
        );
    end

    always_comb begin
        st_d        = st_q;
        ns_vld      = 1'b0;
        ns_tid      = '0;
        ns_seq      = '0;
        ns_uncached = 1'b0;
        trap_vld    = 1'b0;
        trap_tid    = '0;
        clr_ready   = '0;

        st_d.rr = (st_q.rr == TID_W'(THREADS - 1)) ? '0 : st_q.rr + 1'b1;

        for (int t = 0; t < THREADS; t++) begin
            st_d.chg[t] = (off_c[LOOK][t] != '0);
            if (trap_clr[t]) st_d.trap[t] = 1'b0;
        end

        for (int s = 0; s < LOOK; s++) begin
            case (act_c[s])
                ACT_RETIRE: begin
                    st_d.done[tid_c[s]] = seq_c[s];
                    st_d.pc[tid_c[s]]   = npc_c[s];
                    st_d.npc[tid_c[s]]  = npc_c[s] + PC_W'(INSN_BYTES);
                    if (cnt_c[s])
                        st_d.idone[tid_c[s]] = st_d.idone[tid_c[s]] + 1'b1;
                end
                ACT_SQUASH: st_d.sq = st_d.sq + 1'b1;
                ACT_NONSPEC, ACT_UNCACHED: begin
                    ns_vld             = 1'b1;
                    ns_tid             = tid_c[s];
                    ns_seq             = seq_c[s];
                    ns_uncached        = (act_c[s] == ACT_UNCACHED);
                    clr_ready[tid_c[s]] = 1'b1;
                end
                ACT_TRAP: begin
                    trap_vld            = 1'b1;
                    trap_tid            = tid_c[s];
                    st_d.trap[tid_c[s]] = 1'b1;
                end
                default: ;
            endcase
        end

        if (cmt_c[LOOK] == CMT_W'(WIDTH)) st_d.full = st_q.full + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_cnt   = off_c[LOOK];
    assign trap_pend = st_q.trap;
    assign done_seq  = st_q.done;
    assign cmt_pc    = st_q.pc;
    assign cmt_npc   = st_q.npc;
    assign free_upd  = st_q.chg;
    assign idone_cnt = st_q.idone;
    assign sq_cnt    = st_q.sq;
    assign full_cnt  = st_q.full;

    always_comb begin
        for (int t = 0; t < THREADS; t++)
            free_cnt[t] = st_q.chg[t] ? rob_free[t] : '0;
    end

endmodule

// File: rtl/retire_unit_chk.sv
module retire_unit_chk #(
    parameter int THREADS = 2,
    parameter int OFF_W   = 3,
    parameter int TID_W   = 1,
    parameter int CNT_W   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          store_wb_pend,
    input logic [THREADS-1:0][OFF_W-1:0] pop_cnt,
    input logic [THREADS-1:0]            clr_ready,
    input logic                          ns_vld,
    input logic [TID_W-1:0]              ns_tid,
    input logic                          ns_uncached,
    input logic                          trap_vld,
    input logic [TID_W-1:0]              trap_tid,
    input logic [THREADS-1:0]            trap_pend,
    input logic [THREADS-1:0]            free_upd,
    input logic [CNT_W-1:0]              full_cnt
);

    AST_ONE_STOP_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(ns_vld && trap_vld)); // R3

    AST_SERIAL_STORE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_vld && !ns_uncached) |-> !store_wb_pend); // R3

    AST_REQ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ns_vld |-> clr_ready[ns_tid]); // R4

    AST_TRAP_STORE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |-> !store_wb_pend); // R5

    AST_TRAP_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |=> trap_pend[$past(trap_tid)]); // R5

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_cnt == $past(full_cnt)) || (full_cnt == $past(full_cnt) + 1'b1)); // R8

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        AST_PEND_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
            trap_pend[t] |-> (pop_cnt[t] == '0)); // R5

        AST_POP_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_cnt[t] != '0) |=> free_upd[t]); // R9
    end

endmodule

bind retire_unit retire_unit_chk #(
    .THREADS (THREADS),
    .OFF_W   (OFF_W),
    .TID_W   (TID_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .store_wb_pend (store_wb_pend),
    .pop_cnt       (pop_cnt),
    .clr_ready     (clr_ready),
    .ns_vld        (ns_vld),
    .ns_tid        (ns_tid),
    .ns_uncached   (ns_uncached),
    .trap_vld      (trap_vld),
    .trap_tid      (trap_tid),
    .trap_pend     (trap_pend),
    .free_upd      (free_upd),
    .full_cnt      (full_cnt)
);

// File: tb/sim_retire_unit.sv
`timescale 1ns/1ps
module sim_retire_unit;

    localparam int T  = 2;
    localparam int L  = 4;
    localparam int SW = 16;
    localparam int PW = 32;
    localparam int FW = 8;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [T-1:0][L-1:0] hd_valid, hd_ready, hd_squashed, hd_exec;
    logic [T-1:0][L-1:0] hd_serial, hd_load, hd_fault, hd_nocount;
    logic [T-1:0][L-1:0][SW-1:0] hd_seq;
    logic [T-1:0][L-1:0][PW-1:0] hd_npc;
    logic store_wb_pend;
    logic [T-1:0] trap_clr;
    logic [T-1:0][FW-1:0] rob_free;
    logic [T-1:0][2:0] pop_cnt;
    logic [T-1:0] clr_ready;
    logic ns_vld, ns_uncached, trap_vld;
    logic [0:0] ns_tid, trap_tid;
    logic [SW-1:0] ns_seq;
    logic [T-1:0] trap_pend, free_upd;
    logic [T-1:0][SW-1:0] done_seq;
    logic [T-1:0][PW-1:0] cmt_pc, cmt_npc;
    logic [T-1:0][FW-1:0] free_cnt;
    logic [T-1:0][CW-1:0] idone_cnt;
    logic [CW-1:0] sq_cnt, full_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int e_idone0 = 0;
    int e_sq = 0;
    int e_full = 0;

    always #10 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc++;

    retire_unit u0 (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_heads();
        hd_valid = '0; hd_ready = '0; hd_squashed = '0; hd_exec = '0;
        hd_serial = '0; hd_load = '0; hd_fault = '0; hd_nocount = '0;
        hd_seq = '0; hd_npc = '0;
        store_wb_pend = 1'b0; trap_clr = '0;
    endtask

    task automatic put(input int t, input int k, input bit rdy, input bit sq, input bit ex,
                       input bit ser, input bit ld, input bit flt, input bit nc,
                       input int seq, input int npc);
        hd_valid[t][k] = 1'b1; hd_ready[t][k] = rdy; hd_squashed[t][k] = sq;
        hd_exec[t][k] = ex; hd_serial[t][k] = ser; hd_load[t][k] = ld;
        hd_fault[t][k] = flt; hd_nocount[t][k] = nc;
        hd_seq[t][k] = SW'(seq); hd_npc[t][k] = PW'(npc);
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic t_reset();
        clear_heads(); rob_free = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        settle();
        chk("R11", "pop_cnt", pop_cnt, 0);
        chk("R11", "trap_pend", trap_pend, 0);
        chk("R11", "done_seq0", done_seq[0], 0);
        chk("R11", "cmt_pc0", cmt_pc[0], 0);
        chk("R11", "full_cnt", full_cnt, 0);
        chk("R11", "sq_cnt", sq_cnt, 0);
        chk("R11", "free_upd", free_upd, 0);
    endtask

    task automatic t_basic();
        clear_heads();
        for (int k = 0; k < 3; k++) put(0, k, 1, 0, 1, 0, 0, 0, 0, 10 + k, 'h100 + 4 * k);
        rob_free[0] = 8'd5;
        settle();
        chk("R1", "pop_cnt0 width limit", pop_cnt[0], 2);
        chk("R1", "pop_cnt1", pop_cnt[1], 0);
        chk("R1", "ns_vld", ns_vld, 0);
        step();
        e_idone0 += 2; e_full++;
        chk("R6", "done_seq0", done_seq[0], 11);
        chk("R6", "cmt_pc0", cmt_pc[0], 'h104);
        chk("R6", "cmt_npc0", cmt_npc[0], 'h108);
        chk("R7", "idone0", idone_cnt[0], e_idone0);
        chk("R8", "full_cnt", full_cnt, e_full);
        chk("R9", "free_upd0", free_upd[0], 1);
        chk("R9", "free_cnt0", free_cnt[0], 5);
        clear_heads();
        step();
        chk("R9", "free_upd0 idle", free_upd[0], 0);
        chk("R9", "free_cnt0 idle", free_cnt[0], 0);
    endtask

    task automatic t_notready();
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 0, 20, 'h200);
        put(0, 1, 0, 0, 1, 0, 0, 0, 0, 21, 'h204);
        settle();
        chk("R1", "pop stops at not ready", pop_cnt[0], 1);
        step();
        e_idone0++;
        chk("R8", "full unchanged", full_cnt, e_full);
        chk("R6", "done_seq0", done_seq[0], 20);
        clear_heads();
    endtask

    task automatic t_squash();
        clear_heads();
        put(0, 0, 1, 1, 0, 0, 0, 0, 0, 28, 0);
        put(0, 1, 1, 1, 0, 0, 0, 0, 0, 29, 0);
        put(0, 2, 1, 0, 1, 0, 0, 0, 0, 30, 'h300);
        put(0, 3, 1, 0, 1, 0, 0, 0, 0, 31, 'h304);
        settle();
        chk("R2", "pop squashed free", pop_cnt[0], 4);
        step();
        e_sq += 2; e_full++; e_idone0 += 2;
        chk("R2", "sq_cnt", sq_cnt, e_sq);
        chk("R8", "full_cnt", full_cnt, e_full);
        chk("R6", "done_seq0", done_seq[0], 31);
        clear_heads();
        for (int k = 0; k < 4; k++) put(0, k, 1, 1, 0, 0, 0, 0, 0, 32 + k, 0);
        settle();
        chk("R2", "pop all squashed", pop_cnt[0], 4);
        step();
        e_sq += 4;
        chk("R2", "sq_cnt all", sq_cnt, e_sq);
        chk("R8", "full no retire", full_cnt, e_full);
        chk("R6", "done_seq kept", done_seq[0], 31);
        clear_heads();
    endtask

    task automatic t_serial();
        clear_heads();
        put(0, 0, 1, 1, 0, 0, 0, 0, 0, 39, 0);
        put(0, 1, 1, 0, 0, 1, 0, 0, 0, 40, 0);
        settle();
        chk("R3", "pop squashed before serial", pop_cnt[0], 1);
        chk("R3", "ns_vld", ns_vld, 1);
        chk("R3", "ns_seq", ns_seq, 40);
        chk("R3", "ns_uncached", ns_uncached, 0);
        chk("R3", "ns_tid", ns_tid, 0);
        chk("R3", "clr_ready", clr_ready, 1);
        store_wb_pend = 1'b1;
        settle();
        chk("R3", "stores pending no req", ns_vld, 0);
        chk("R3", "stores pending clr", clr_ready, 0);
        chk("R3", "stores pending pop", pop_cnt[0], 1);
        step();
        e_sq++;
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 0, 41, 'h400);
        put(0, 1, 1, 0, 0, 1, 0, 0, 0, 42, 0);
        settle();
        chk("R3", "serial not slot0 pop", pop_cnt[0], 1);
        chk("R3", "serial not slot0 no req", ns_vld, 0);
        step();
        e_idone0++;
        chk("R2", "sq_cnt", sq_cnt, e_sq);
        clear_heads();
    endtask

    task automatic t_load();
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 0, 50, 'h500);
        put(0, 1, 1, 0, 0, 0, 1, 0, 0, 51, 0);
        store_wb_pend = 1'b1;
        settle();
        chk("R4", "pop before load", pop_cnt[0], 1);
        chk("R4", "ns_vld", ns_vld, 1);
        chk("R4", "ns_uncached", ns_uncached, 1);
        chk("R4", "ns_seq", ns_seq, 51);
        chk("R4", "clr_ready", clr_ready, 1);
        step();
        e_idone0++;
        clear_heads();
    endtask

    task automatic t_fault();
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 1, 0, 60, 0);
        store_wb_pend = 1'b1;
        settle();
        chk("R5", "store gate trap", trap_vld, 0);
        chk("R5", "store gate pop", pop_cnt[0], 0);
        step();
        chk("R5", "no pend", trap_pend, 0);
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 0, 61, 'h600);
        put(0, 1, 1, 0, 1, 0, 0, 1, 0, 62, 0);
        settle();
        chk("R5", "fault after retire pop", pop_cnt[0], 1);
        chk("R5", "fault after retire trap", trap_vld, 0);
        step();
        e_idone0++;
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 1, 0, 63, 0);
        settle();
        chk("R5", "trap_vld", trap_vld, 1);
        chk("R5", "trap_tid", trap_tid, 0);
        chk("R5", "trap pop", pop_cnt[0], 0);
        step();
        chk("R5", "trap_pend", trap_pend, 1);
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 0, 64, 'h640);
        settle();
        chk("R5", "pending blocks pop", pop_cnt[0], 0);
        trap_clr[0] = 1'b1;
        step();
        trap_clr = '0;
        chk("R5", "trap_clr", trap_pend, 0);
        settle();
        chk("R5", "resume pop", pop_cnt[0], 1);
        step();
        e_idone0++;
        chk("R6", "done_seq0", done_seq[0], 64);
        clear_heads();
    endtask

    task automatic t_nocount();
        clear_heads();
        put(0, 0, 1, 0, 1, 0, 0, 0, 1, 70, 'h700);
        put(0, 1, 1, 0, 1, 0, 0, 0, 0, 71, 'h704);
        settle();
        chk("R7", "pop", pop_cnt[0], 2);
        step();
        e_idone0++; e_full++;
        chk("R7", "idone excludes nop", idone_cnt[0], e_idone0);
        chk("R8", "full_cnt", full_cnt, e_full);
        clear_heads();
    endtask

    task automatic t_select();
        clear_heads();
        for (int k = 0; k < 2; k++) begin
            put(0, k, 1, 0, 1, 0, 0, 0, 0, 80 + k, 'h800 + 4 * k);
            put(1, k, 1, 0, 1, 0, 0, 0, 0, 90 + k, 'h900 + 4 * k);
        end
        for (int rep = 0; rep < 2; rep++) begin
            int rr;
            rr = cyc % 2;
            settle();
            chk("R10", "pop selected", pop_cnt[rr], 2);
            chk("R10", "pop other", pop_cnt[1 - rr], 0);
            step();
            e_full++;
            if (rr == 0) e_idone0 += 2;
            chk("R10", "done_seq selected", done_seq[rr], (rr == 0) ? 81 : 91);
            chk("R8", "full_cnt", full_cnt, e_full);
        end
        chk("R7", "idone0", idone_cnt[0], e_idone0);
        chk("R6", "cmt_npc1", cmt_npc[1], 'h908);
        clear_heads();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_notready();
        t_squash();
        t_serial();
        t_load();
        t_fault();
        t_nocount();
        t_select();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule